// File: doc/BRIEF.md
# Two-way write-back data cache

This block is a small data cache for a single-issue processor. It has two ways, named left and right, and four sets. Each line holds one 32-bit word. A processor read that hits returns its word in the same cycle. A read that misses picks a victim way. If that victim holds modified data, the block first writes the victim word back to memory, then fetches the requested word into the victim way. The processor then completes its request by hitting the new line.

Writes follow a write-back policy without allocation. A write that hits changes only the cached word and marks the line dirty. A write that misses goes straight to memory and leaves every cache array untouched. Each set keeps one replacement bit that names the most recently touched way, and the other way is evicted when both ways are valid.

The processor holds its request (address, direction and write data) stable until it sees `cpu_ready` high. A request completes in the cycle where `cpu_req` and `cpu_ready` are both high. On the memory side, `mem_req` stays high with stable address, direction and data until memory answers with a one-cycle `mem_ack`. Read data on `mem_rdata` is valid in the cycle of that acknowledge.

Top module: `dc2_cache`

## Requirements
- R1: After reset no line is valid or dirty. With no memory transaction pending, `mem_req` is low and `cpu_ready` is low, and the first read of any address fetches it from memory.
- R2: A byte address is split into tag `[31:4]`, set index `[3:2]` and ignored byte offset `[1:0]`. Addresses that differ only in bits `[1:0]` name the same word. Every memory address issued has bits `[1:0]` equal to zero. A set is affected only by accesses whose index selects it.
- R3: A read that hits raises `cpu_ready` in the cycle the request is presented, returns the cached word on `cpu_rdata`, and starts no memory transaction.
- R4: A write that hits updates only the cached word, completes in the cycle it is presented, marks the line dirty and does not write memory at that time.
- R5: A write that misses performs exactly one memory write of the word to its word-aligned address. It does not allocate: the tags, valid bits, dirty bits, data and replacement bit of that set stay unchanged, so a later read of that address misses.
- R6: On a read miss the victim is an invalid way if there is one, left before right. Otherwise it is the way that the set's replacement bit does not mark as most recent.
- R7: When the victim of a read miss is valid and dirty, its word is written to memory at its own address before the requested word is fetched. A clean victim causes no memory write.
- R8: A read-miss fill fetches the requested word address, leaves the line valid and clean, and returns the fetched word to the processor. `cpu_ready` is high in the cycle after the fill acknowledge, and the set's replacement bit then names the filled way.
- R9: A read hit or a write hit sets that set's replacement bit to the way that hit. The value 1 means left is most recent and 0 means right is most recent.
- R10: `cpu_ready` is low while any memory transaction is outstanding. `mem_req`, `mem_we` and `mem_addr` hold their values from request until acknowledge. Requests complete one at a time, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request valid, held until completion |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write word |
| cpu_rdata | output | 32 | Read word, valid when a read completes |
| cpu_ready | output | 1 | Request completes this cycle |
| mem_req | output | 1 | Memory transaction requested |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, valid with mem_ack |
| mem_ack | input | 1 | One-cycle memory completion |

## Verification
The bench builds the cache with its default parameters: 32-bit addresses and data, a 2-bit index and a 2-bit offset, which gives four sets and 28-bit tags. With only four sets, addresses 16 bytes apart collide in one set. That is enough to walk a set through every victim case: an invalid way, a clean and a dirty way on either side, and a replacement bit moved by a hit. A memory model with a fixed latency lets the bench count memory reads and writes per access. It also lets the bench compare every read against a shadow copy of memory.

// File: rtl/dc2_pkg.sv
package dc2_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WMISS = 3'd1,
    ST_WBACK = 3'd2,
    ST_FILL  = 3'd3,
    ST_DONE  = 3'd4
  } dc2_state_e;

endpackage

// File: rtl/dc2_way.sv
// One way of the cache: valid, dirty, tag and data per set, one write port.
module dc2_way #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 28,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  cmp_tag,
  output logic              hit,
  output logic              line_valid,
  output logic              line_dirty,
  output logic [TAG_W-1:0]  line_tag,
  output logic [DATA_W-1:0] line_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_dirty
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   valid_q, valid_d;
  logic [SETS-1:0]   dirty_q, dirty_d;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
      dirty_d[wr_idx] = wr_dirty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign line_valid = valid_q[rd_idx];
  assign line_dirty = dirty_q[rd_idx];
  assign line_tag   = tag_q[rd_idx];
  assign line_data  = data_q[rd_idx];
  assign hit        = line_valid && (line_tag == cmp_tag);

endmodule

// File: rtl/dc2_lru.sv
// Per-set recency bit: 1 = left way touched last, 0 = right way.
module dc2_lru #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_left,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             left_recent
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] mru_q, mru_d;

  always_comb begin
    mru_d = mru_q;
    if (touch_en) mru_d[touch_idx] = touch_left;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mru_q <= '0;
    else if (touch_en) mru_q <= mru_d;
  end

  assign left_recent = mru_q[rd_idx];

endmodule

// File: rtl/dc2_ctrl.sv
// Miss sequencer: write-through on write miss, optional writeback then fill on read miss.
module dc2_ctrl
  import dc2_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req,
  input  logic       cpu_we,
  input  logic       hit,
  input  logic       victim_dirty,
  input  logic       mem_ack,
  output dc2_state_e state,
  output logic       miss_start
);
  dc2_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    miss_start = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req && !hit) begin
          if (cpu_we) begin
            state_d = ST_WMISS;
          end else begin
            miss_start = 1'b1;
            state_d    = victim_dirty ? ST_WBACK : ST_FILL;
          end
        end
      end
      ST_WMISS: if (mem_ack) state_d = ST_DONE;
      ST_WBACK: if (mem_ack) state_d = ST_FILL;
      ST_FILL:  if (mem_ack) state_d = ST_IDLE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/dc2_cache.sv
// Two-way, one-word-line data cache: write-back, no allocate on write miss.
module dc2_cache
  import dc2_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int NWAYS = 2;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             unused_off;

  assign idx        = cpu_addr[OFF_W +: IDX_W];
  assign tag        = cpu_addr[ADDR_W-1 -: TAG_W];
  assign unused_off = ^cpu_addr[OFF_W-1:0];

  logic [NWAYS-1:0]  way_hit, way_valid, way_dirty, way_wr;
  logic [TAG_W-1:0]  way_tag  [NWAYS];
  logic [DATA_W-1:0] way_data [NWAYS];
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;
  logic              wr_dirty;

  dc2_state_e state;
  logic       miss_start, hit_any, left_recent;
  logic       victim_sel, victim_q, victim_dirty;
  logic       touch_en, touch_left;

  assign hit_any = |way_hit;

  genvar w;
  generate
    for (w = 0; w < NWAYS; w++) begin : g_way
      dc2_way #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_way (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (idx),
        .cmp_tag    (tag),
        .hit        (way_hit[w]),
        .line_valid (way_valid[w]),
        .line_dirty (way_dirty[w]),
        .line_tag   (way_tag[w]),
        .line_data  (way_data[w]),
        .wr_en      (way_wr[w]),
        .wr_idx     (idx),
        .wr_tag     (wr_tag),
        .wr_data    (wr_data),
        .wr_dirty   (wr_dirty)
      );
    end
  endgenerate

  // Victim: first invalid way, else the way not marked most recent.
  always_comb begin
    if (!way_valid[0])      victim_sel = 1'b0;
    else if (!way_valid[1]) victim_sel = 1'b1;
    else                    victim_sel = left_recent;
    victim_dirty = way_valid[victim_sel] && way_dirty[victim_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          victim_q <= 1'b0;
    else if (miss_start) victim_q <= victim_sel;
  end

  dc2_ctrl i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .hit          (hit_any),
    .victim_dirty (victim_dirty),
    .mem_ack      (mem_ack),
    .state        (state),
    .miss_start   (miss_start)
  );

  logic idle_hit, fill_done;
  assign idle_hit  = (state == ST_IDLE) && cpu_req && hit_any;
  assign fill_done = (state == ST_FILL) && mem_ack;

  always_comb begin
    for (int i = 0; i < NWAYS; i++) begin
      way_wr[i] = (idle_hit && cpu_we && way_hit[i]) ||
                  (fill_done && (victim_q == 1'(i)));
    end
    wr_tag   = tag;
    wr_data  = fill_done ? mem_rdata : cpu_wdata;
    wr_dirty = !fill_done;
  end

  assign touch_en   = idle_hit || fill_done;
  assign touch_left = fill_done ? (victim_q == 1'b0) : way_hit[0];

  dc2_lru #(.IDX_W(IDX_W)) i_lru (
    .clk         (clk),
    .rst_n       (rst_n),
    .touch_en    (touch_en),
    .touch_idx   (idx),
    .touch_left  (touch_left),
    .rd_idx      (idx),
    .left_recent (left_recent)
  );

  assign cpu_ready = idle_hit || (state == ST_DONE);
  assign cpu_rdata = way_hit[0] ? way_data[0] : way_data[1];

  always_comb begin
    mem_req   = (state == ST_WMISS) || (state == ST_WBACK) || (state == ST_FILL);
    mem_we    = (state == ST_WMISS) || (state == ST_WBACK);
    mem_addr  = {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    mem_wdata = cpu_wdata;
    if (state == ST_WBACK) begin
      mem_addr  = {way_tag[victim_q], idx, {OFF_W{1'b0}}};
      mem_wdata = way_data[victim_q];
    end
  end

endmodule

// File: rtl/dc2_cache_chk.sv
module dc2_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);
  // R10
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  // R2
  mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));

  // R8
  fill_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr[ADDR_W-1:OFF_W] == cpu_addr[ADDR_W-1:OFF_W]));

  // R8
  fill_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> cpu_ready);

endmodule

bind dc2_cache dc2_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_ready (cpu_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack)
);

// File: tb/test_dc2_cache.sv
`timescale 1ns/1ps
module test_dc2_cache;
  localparam int MEM_LAT = 2;

  logic        clk, rst_n;
  logic        cpu_req, cpu_we, cpu_ready;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  dc2_cache i_dc2_cache (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0, lat = 0;
  bit finished = 0;
  logic [31:0] mem_arr [0:255];
  logic [31:0] shadow  [0:255];
  logic [31:0] exp_q [$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // memory model, fixed latency, one-cycle acknowledge
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    for (int i = 0; i < 256; i++) begin
      mem_arr[i] = 32'h5A00_0000 | i;
      shadow[i]  = 32'h5A00_0000 | i;
    end
  end

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (lat == MEM_LAT) begin
        lat = 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem_arr[mem_addr[9:2]] = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata <= mem_arr[mem_addr[9:2]];
          rd_cnt++;
        end
      end else begin
        lat++;
      end
    end
  end

  // monitor: read completions against the scoreboard, ready during memory traffic
  always @(negedge clk) begin
    if (rst_n && cpu_req && cpu_ready && !cpu_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected read completion", cpu_rdata, '0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(cpu_rdata == e, "R8", "read data", cpu_rdata, e);
      end
    end
    if (rst_n && mem_req) chk(!cpu_ready, "R10", "ready during memory transaction",
                              {31'd0, cpu_ready}, 32'd0);
  end

  task automatic acc(input logic we, input logic [31:0] a, input logic [31:0] wd,
                     input int erd, input int ewr, input string rq);
    int rd0, wr0, waits;
    rd0 = rd_cnt;
    wr0 = wr_cnt;
    waits = 0;
    if (!we) exp_q.push_back(shadow[a[9:2]]);
    else     shadow[a[9:2]] = wd;
    @(posedge clk); #2;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    forever begin
      @(negedge clk);
      if (cpu_ready) break;
      waits++;
    end
    @(posedge clk); #2;
    cpu_req = 1'b0;
    chk(rd_cnt - rd0 == erd, rq, "memory reads", 32'(rd_cnt - rd0), 32'(erd));
    chk(wr_cnt - wr0 == ewr, rq, "memory writes", 32'(wr_cnt - wr0), 32'(ewr));
    if (erd == 0 && ewr == 0)
      chk(waits == 0, rq, "hit latency", 32'(waits), 32'd0);
  endtask

  localparam logic [31:0] A = 32'h000, B = 32'h010, C = 32'h020, D = 32'h030, E = 32'h004;

  initial begin
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!mem_req, "R1", "mem_req after reset", {31'd0, mem_req}, 32'd0);
    chk(!cpu_ready, "R1", "cpu_ready after reset", {31'd0, cpu_ready}, 32'd0);
    // R1 first read misses; R6 invalid left way is filled
    acc(1'b0, A, '0, 1, 0, "R1");
    // R2 offset ignored, R3 read hit
    acc(1'b0, A + 32'd3, '0, 0, 0, "R3");
    // R4 write hit: cached only
    acc(1'b1, A, 32'h1111_1111, 0, 0, "R4");
    chk(mem_arr[0] == 32'h5A00_0000, "R4", "memory untouched by write hit", mem_arr[0], 32'h5A00_0000);
    acc(1'b0, A, '0, 0, 0, "R4");
    // R5 write miss goes to memory, no allocation
    acc(1'b1, B, 32'h2222_2222, 0, 1, "R5");
    chk(mem_arr[4] == 32'h2222_2222, "R5", "write miss word in memory", mem_arr[4], 32'h2222_2222);
    acc(1'b0, A, '0, 0, 0, "R5");
    acc(1'b0, B, '0, 1, 0, "R5");
    // R6 second invalid way used: A still hits
    acc(1'b0, A, '0, 0, 0, "R6");
    // set0: left A dirty, right B clean; last touched left (A)
    // touch B so right is most recent, then C evicts left (dirty A)
    acc(1'b0, B, '0, 0, 0, "R9");
    acc(1'b0, C, '0, 1, 1, "R7");
    chk(mem_arr[0] == 32'h1111_1111, "R7", "dirty victim written back", mem_arr[0], 32'h1111_1111);
    // R6 D evicts right (B, clean): no memory write
    acc(1'b0, D, '0, 1, 0, "R7");
    // R9 hit on C makes left most recent, so B evicts D on the right
    acc(1'b0, C, '0, 0, 0, "R9");
    acc(1'b0, B, '0, 1, 0, "R9");
    acc(1'b0, C, '0, 0, 0, "R9");
    // R4 write hit on right way, then A evicts clean C (R8 fill left it clean)
    acc(1'b1, B, 32'h3333_3333, 0, 0, "R4");
    acc(1'b0, A, '0, 1, 0, "R8");
    // D evicts right (dirty B)
    acc(1'b0, D, '0, 1, 1, "R7");
    chk(mem_arr[4] == 32'h3333_3333, "R7", "right dirty victim written back", mem_arr[4], 32'h3333_3333);
    // R2 another set is independent
    acc(1'b0, E, '0, 1, 0, "R2");
    acc(1'b0, A, '0, 0, 0, "R2");
    acc(1'b0, D, '0, 0, 0, "R2");
    // R5 write miss in an empty set, then read misses
    acc(1'b1, 32'h008, 32'h4444_4444, 0, 1, "R5");
    acc(1'b0, 32'h008, '0, 1, 0, "R5");
    chk(exp_q.size() == 0, "R10", "all reads completed", 32'(exp_q.size()), 32'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R10", "watchdog expired", '0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule